// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits on the host side of an 8-bit NAND flash bus whose command, address and data cycles share one I/O byte. It accepts one operation at a time from a request port: page read, page program, block erase, status read, signature read or device reset. For each operation it generates the matching sequence of command-latch, address-latch and data strobes on the flash pins. Where the device signals busy it waits on ready/busy, and it moves payload bytes through two byte-wide valid/ready streams, one for writes and one for reads.

Read and program operations begin with an area pointer command. The pointer selects the first half page, the second half page or the spare region. The number of address cycles is fixed by a density parameter: a full address carries the column byte first and then the row bytes, least significant first, while an erase sends only the row bytes. The write-enable low and high widths, the read-enable access time, the gap between ready and the first read strobe, and the busy timeout are run-time inputs counted in clock cycles. A host-side write-protect enable both drives the flash write-protect pin and lets the block refuse program and erase requests.

Top module: `nand_seq`

## Requirements
- R1: Every command cycle has command latch high, address latch low and chip enable low when write enable rises, and the block drives the I/O byte (nf_dq_oe high) whenever write enable is low. Read enable and write enable are never low together.
- R2: Address cycles have address latch high and command latch low. A read or a program sends ADDR_CYCLES bytes: the column byte first, then the row bytes, least significant byte first.
- R3: Read and program start with a pointer command chosen by req_area: 0 sends 00h (first half page), 1 sends 01h (second half page), 2 sends 50h (spare area) and 3 sends 00h.
- R4: For req_area 2 the column address byte carries only req_col[3:0], and its upper four bits are sent as zero.
- R5: A program (req_op 1) sends the pointer, then 80h, then the address, then req_len bytes taken in order from the write stream, then 10h. It then waits for ready/busy to return high before it raises done.
- R6: An erase (req_op 2) sends 60h, then ADDR_CYCLES-1 row bytes (least significant byte first, no column byte), then D0h, and waits for ready.
- R7: A status read (req_op 3) sends 70h and returns one byte. A signature read (req_op 4) sends 90h and one 00h address byte, then returns exactly two bytes.
- R8: A reset (req_op 5) sends FFh and raises done only after ready/busy has returned high.
- R9: A page read (req_op 0) returns req_len bytes. Its first read-enable fall comes only after ready/busy is high, and at least cfg_rr_delay cycles after the rising edge of ready/busy.
- R10: Write enable stays low for cfg_we_low cycles and high for cfg_we_high cycles, where a value of 0 acts as 1. Read enable stays low for cfg_re_access cycles.
- R11: If ready/busy stays low for more than cfg_busy_limit cycles of a wait, the operation ends with done and err both high.
- R12: nf_wp_n follows wp_allow. When wp_allow is low, a program or erase request produces no bus cycle and ends with done and err on the cycle after acceptance.
- R13: rd_valid and rd_data hold steady until rd_ready, and no read-enable pulse happens while a byte is waiting.
- R14: req_op 6 and 7 are undefined. They produce no bus cycle and end with done and err on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 signature, 5 reset |
| req_area | input | 2 | Area pointer: 0 first half, 1 second half, 2 spare |
| req_col | input | 8 | Column byte |
| req_row | input | ROW_W | Row address, sent least significant byte first |
| req_len | input | LEN_W | Byte count for read and program (0 acts as 1) |
| wp_allow | input | 1 | Program/erase allowed; drives the write-protect pin |
| cfg_we_low | input | STRB_W | Write-enable low width in cycles |
| cfg_we_high | input | STRB_W | Write-enable high width in cycles |
| cfg_re_access | input | STRB_W | Read-enable low time before sampling |
| cfg_rr_delay | input | STRB_W | Ready-to-first-read-enable gap |
| cfg_busy_limit | input | BUSY_W | Busy timeout in cycles |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte present |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Error flag, valid with done |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write enable, active low |
| nf_re_n | output | 1 | Flash read enable, active low |
| nf_wp_n | output | 1 | Flash write protect, active low |
| nf_dq_o | output | 8 | I/O byte driven to flash |
| nf_dq_oe | output | 1 | I/O byte drive enable |
| nf_dq_i | input | 8 | I/O byte from flash |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
Page reads use each of the three area values. The pointer byte shows whether the area mapping is right, and the spare read with a full column byte shows whether the column byte is masked. Program and erase transactions are compared strobe by strobe against the expected command, address and data sequence. This separates full-address ordering from erase's row-only ordering, and shows whether payload bytes arrive in stream order. Status, signature and reset each check their own command byte and byte count. A device held busy too long, a refused write-protected program, an undefined opcode and a stalled read stream are each tried apart, to tell an error exit from a normal exit and to show that the bus stays quiet while the host stalls.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int ADDR_CYCLES = 3,
  parameter int STRB_W      = 4,
  parameter int BUSY_W      = 16,
  parameter int LEN_W       = 10,
  parameter int RB_GUARD    = 2,
  localparam int ROW_W      = 8 * (ADDR_CYCLES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_area,
  input  logic [7:0]        req_col,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wp_allow,
  input  logic [STRB_W-1:0] cfg_we_low,
  input  logic [STRB_W-1:0] cfg_we_high,
  input  logic [STRB_W-1:0] cfg_re_access,
  input  logic [STRB_W-1:0] cfg_rr_delay,
  input  logic [BUSY_W-1:0] cfg_busy_limit,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              done,
  output logic              err,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic              nf_wp_n,
  output logic [7:0]        nf_dq_o,
  output logic              nf_dq_oe,
  input  logic [7:0]        nf_dq_i,
  input  logic              nf_rb
);

  localparam logic [2:0] OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
                         OP_STAT = 3'd3, OP_SIG  = 3'd4, OP_RST   = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_CMD1, S_ADDR, S_DIN, S_CMD2, S_BUSY, S_RDLY, S_DOUT, S_DONE
  } st_t;

  st_t              st;
  logic [2:0]       op_q;
  logic [1:0]       area_q;
  logic [7:0]       col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] left_q;
  logic [2:0]       aidx;
  logic             ph;
  logic             loaded;
  logic [7:0]       dbuf;
  logic             err_q;
  logic [BUSY_W-1:0] tcnt;

  logic [STRB_W-1:0] lo_m1, hi_m1, acc_m1, rr_m1;
  assign lo_m1  = (cfg_we_low    == '0) ? '0 : cfg_we_low    - 1'b1;
  assign hi_m1  = (cfg_we_high   == '0) ? '0 : cfg_we_high   - 1'b1;
  assign acc_m1 = (cfg_re_access == '0) ? '0 : cfg_re_access - 1'b1;
  assign rr_m1  = (cfg_rr_delay  == '0) ? '0 : cfg_rr_delay  - 1'b1;

  logic wr_state, we_lo_end, we_hi_end, last_addr;
  assign wr_state  = (st == S_PTR) || (st == S_CMD1) || (st == S_ADDR) ||
                     (st == S_CMD2) || (st == S_DIN && loaded);
  assign we_lo_end = wr_state && !ph && (tcnt >= BUSY_W'(lo_m1));
  assign we_hi_end = wr_state &&  ph && (tcnt >= BUSY_W'(hi_m1));
  assign last_addr = (op_q == OP_SIG) || (aidx == 3'(ADDR_CYCLES - 1));

  logic bad_op, wp_block;
  assign bad_op   = (req_op > OP_RST);
  assign wp_block = (req_op == OP_PROG || req_op == OP_ERASE) && !wp_allow;

  logic [7:0] ptr_code, cmd1_code, addr_byte, cmd2_code;
  assign ptr_code = (area_q == 2'd1) ? 8'h01 : (area_q == 2'd2) ? 8'h50 : 8'h00;

  always_comb begin
    case (op_q)
      OP_PROG:  cmd1_code = 8'h80;
      OP_ERASE: cmd1_code = 8'h60;
      OP_STAT:  cmd1_code = 8'h70;
      OP_SIG:   cmd1_code = 8'h90;
      default:  cmd1_code = 8'hFF;
    endcase
  end

  assign cmd2_code = (op_q == OP_ERASE) ? 8'hD0 : 8'h10;
  assign addr_byte = (op_q == OP_SIG) ? 8'h00 :
                     (aidx != 3'd0)   ? row_q[7:0] :
                     (area_q == 2'd2) ? {4'h0, col_q[3:0]} : col_q;

  always_comb begin
    case (st)
      S_PTR:   nf_dq_o = ptr_code;
      S_CMD1:  nf_dq_o = cmd1_code;
      S_ADDR:  nf_dq_o = addr_byte;
      S_DIN:   nf_dq_o = dbuf;
      S_CMD2:  nf_dq_o = cmd2_code;
      default: nf_dq_o = 8'h00;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_DIN) && !loaded;
  assign done      = (st == S_DONE);
  assign err       = err_q;
  assign nf_ce_n   = (st == S_IDLE) || (st == S_DONE);
  assign nf_cle    = (st == S_PTR) || (st == S_CMD1) || (st == S_CMD2);
  assign nf_ale    = (st == S_ADDR);
  assign nf_we_n   = !(wr_state && !ph);
  assign nf_re_n   = !(st == S_DOUT && !rd_valid);
  assign nf_wp_n   = wp_allow;
  assign nf_dq_oe  = wr_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; area_q <= '0; col_q <= '0; row_q <= '0;
      left_q <= '0; aidx <= '0; ph <= 1'b0; loaded <= 1'b0; dbuf <= '0;
      err_q <= 1'b0; tcnt <= '0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          area_q <= req_area;
          col_q  <= req_col;
          row_q  <= req_row;
          aidx   <= (req_op == OP_ERASE) ? 3'd1 : 3'd0;
          ph     <= 1'b0;
          tcnt   <= '0;
          err_q  <= 1'b0;
          if (req_op == OP_STAT)     left_q <= LEN_W'(1);
          else if (req_op == OP_SIG) left_q <= LEN_W'(2);
          else                       left_q <= (req_len == '0) ? LEN_W'(1) : req_len;
          if (bad_op || wp_block) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else if (req_op == OP_READ || req_op == OP_PROG) st <= S_PTR;
          else st <= S_CMD1;
        end
        S_PTR, S_CMD1, S_ADDR, S_DIN, S_CMD2: begin
          if (st == S_DIN && !loaded && wr_valid) begin
            dbuf   <= wr_data;
            loaded <= 1'b1;
          end
          if (we_lo_end) begin
            ph   <= 1'b1;
            tcnt <= '0;
          end else if (we_hi_end) begin
            ph   <= 1'b0;
            tcnt <= '0;
            case (st)
              S_PTR:  st <= (op_q == OP_READ) ? S_ADDR : S_CMD1;
              S_CMD1: case (op_q)
                        OP_STAT: st <= S_RDLY;
                        OP_RST:  st <= S_BUSY;
                        default: st <= S_ADDR;
                      endcase
              S_ADDR: begin
                if (aidx != 3'd0) row_q <= row_q >> 8;
                aidx <= aidx + 3'd1;
                if (last_addr) begin
                  case (op_q)
                    OP_READ:  st <= S_BUSY;
                    OP_PROG:  st <= S_DIN;
                    OP_ERASE: st <= S_CMD2;
                    default:  st <= S_RDLY;
                  endcase
                end
              end
              S_DIN: begin
                loaded <= 1'b0;
                left_q <= left_q - 1'b1;
                if (left_q == LEN_W'(1)) st <= S_CMD2;
              end
              default: st <= S_BUSY;
            endcase
          end else if (wr_state) tcnt <= tcnt + 1'b1;
        end
        S_BUSY: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt >= BUSY_W'(RB_GUARD) && nf_rb) begin
            tcnt <= '0;
            st   <= (op_q == OP_READ) ? S_RDLY : S_DONE;
          end else if (tcnt >= cfg_busy_limit) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end
        end
        S_RDLY: begin
          if (tcnt >= BUSY_W'(rr_m1)) begin
            tcnt <= '0;
            st   <= S_DOUT;
          end else tcnt <= tcnt + 1'b1;
        end
        S_DOUT: begin
          if (rd_valid) begin
            if (rd_ready) begin
              rd_valid <= 1'b0;
              tcnt     <= '0;
              left_q   <= left_q - 1'b1;
              if (left_q == LEN_W'(1)) st <= S_DONE;
            end
          end else if (tcnt >= BUSY_W'(acc_m1)) begin
            rd_data  <= nf_dq_i;
            rd_valid <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       wp_allow,
  input logic       done,
  input logic       err,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_dq_oe
);

  a_r1_cmd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) && nf_cle |-> !nf_ale && !nf_ce_n);

  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  a_r1_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> nf_dq_oe && nf_re_n);

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  a_r12_wp_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_op == 3'd1 || req_op == 3'd2) && !wp_allow
    |=> done && err && nf_we_n);

  a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r13_no_re_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> nf_re_n);

  a_r14_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op > 3'd5 |=> done && err);

endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .wp_allow(wp_allow), .done(done), .err(err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe)
);

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, wp_allow = 1, wr_valid = 0, rd_ready = 1;
  logic [2:0] req_op = 0;
  logic [1:0] req_area = 0;
  logic [7:0] req_col = 0, wr_data = 0;
  logic [15:0] req_row = 0;
  logic [9:0] req_len = 1;
  logic [3:0] cfg_we_low = 2, cfg_we_high = 2, cfg_re_access = 2, cfg_rr_delay = 3;
  logic [15:0] cfg_busy_limit = 500;
  logic [7:0] nf_dq_i = 0;
  logic nf_rb = 1;
  logic req_ready, wr_ready, rd_valid, done, err;
  logic [7:0] rd_data, nf_dq_o;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_dq_oe;

  nand_seq uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model: strobe log, busy generator, read data
  logic [9:0] lg [0:31];
  int lg_n = 0, acnt = 0, trig_addr_n = 0, busy_cycles = 5, rbc = 0, r1_bad = 0;
  int rcnt = 0, re_falls = 0;
  bit trig = 0;
  logic [7:0] dbase = 8'hA0;
  realtime t_we_fall, t_re_fall, t_rb_rise, t_first_re;
  realtime we_lo_min, we_lo_max, re_lo_min, re_lo_max;
  bit first_re_rb;

  always @(negedge nf_we_n) t_we_fall = $realtime;
  always @(posedge nf_we_n) begin
    if ($realtime - t_we_fall < we_lo_min) we_lo_min = $realtime - t_we_fall;
    if ($realtime - t_we_fall > we_lo_max) we_lo_max = $realtime - t_we_fall;
    if (nf_ce_n || !nf_dq_oe || (nf_cle && nf_ale) || !nf_re_n) r1_bad++;
    if (lg_n < 32) lg[lg_n] = {nf_cle ? 2'd1 : nf_ale ? 2'd2 : 2'd3, nf_dq_o};
    lg_n++;
    if (nf_cle) begin
      acnt = 0;
      if (nf_dq_o == 8'h10 || nf_dq_o == 8'hD0 || nf_dq_o == 8'hFF) trig = 1;
    end else if (nf_ale) begin
      acnt++;
      if (acnt == trig_addr_n) trig = 1;
    end
  end
  always @(negedge clk) begin
    if (trig) begin
      trig = 0; nf_rb = 0; rbc = busy_cycles;
    end else if (rbc > 0) begin
      rbc--;
      if (rbc == 0) begin nf_rb = 1; t_rb_rise = $realtime; end
    end
  end
  always @(negedge nf_re_n) begin
    t_re_fall = $realtime;
    if (re_falls == 0) begin t_first_re = $realtime; first_re_rb = nf_rb; end
    re_falls++;
    nf_dq_i <= dbase + 8'(rcnt);
    rcnt++;
  end
  always @(posedge nf_re_n) begin
    if ($realtime - t_re_fall < re_lo_min) re_lo_min = $realtime - t_re_fall;
    if ($realtime - t_re_fall > re_lo_max) re_lo_max = $realtime - t_re_fall;
  end

  logic [7:0] rx [0:15];
  int rx_n = 0;
  always @(negedge clk) if (rd_valid && rd_ready && rx_n < 16) begin rx[rx_n] = rd_data; rx_n++; end

  logic [9:0] ex [0:31];
  int ex_n = 0;
  bit got_err;
  realtime t_done;

  task automatic clear();
    lg_n = 0; ex_n = 0; rx_n = 0; rcnt = 0; re_falls = 0; r1_bad = 0;
    we_lo_min = 1e9; we_lo_max = 0; re_lo_min = 1e9; re_lo_max = 0;
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] v);
    ex[ex_n] = {k, v}; ex_n++;
  endtask

  task automatic check_log(input string req);
    chk(lg_n == ex_n, {req, " strobe count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++)
      chk(lg[i] == ex[i], {req, " strobe entry"}, int'(lg[i]), int'(ex[i]));
    chk(r1_bad == 0, "R1 latch levels at write-enable rise", r1_bad, 0);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] area, input logic [7:0] col,
                        input logic [15:0] row, input logic [9:0] len, input int nwr);
    int k;
    @(posedge clk); #1;
    req_op = op; req_area = area; req_col = col; req_row = row; req_len = len; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    for (int i = 0; i < nwr; i++) begin
      wr_data = 8'h50 + 8'(i); wr_valid = 1;
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      @(posedge clk); #1 wr_valid = 0;
    end
    k = 0;
    @(negedge clk);
    while (!done && k < 20000) begin @(negedge clk); k++; end
    got_err = err; t_done = $realtime;
  endtask

  task automatic wait_ready();
    while (!nf_rb) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(req_ready && nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !done && !rd_valid,
        "R1 idle pins after reset", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);
  endtask

  task automatic t_read(input logic [1:0] area, input logic [7:0] col, input logic [7:0] ptr,
                        input logic [7:0] colx, input string req);
    clear(); trig_addr_n = 3; busy_cycles = 6; dbase = 8'hA0 + 8'(area);
    push(1, ptr); push(2, colx); push(2, 8'h34); push(2, 8'h12);
    run_op(3'd0, area, col, 16'h1234, 10'd3, 0);
    check_log(req);
    chk(!got_err, "R9 read no error", got_err, 0);
    chk(rx_n == 3, "R9 read byte count", rx_n, 3);
    for (int i = 0; i < rx_n && i < 3; i++)
      chk(rx[i] == dbase + 8'(i), "R9 read data", rx[i], dbase + 8'(i));
    chk(first_re_rb, "R9 first read strobe after ready", first_re_rb, 1);
    chk(t_first_re - t_rb_rise >= 15.0, "R9 ready-to-read gap", int'(t_first_re - t_rb_rise), 15);
    chk(we_lo_min == 10.0 && we_lo_max == 10.0, "R10 write-enable low width", int'(we_lo_max), 10);
    chk(re_lo_min == 10.0 && re_lo_max == 10.0, "R10 read-enable low width", int'(re_lo_max), 10);
  endtask

  task automatic t_program();
    clear(); trig_addr_n = 0; busy_cycles = 8; cfg_we_low = 0; cfg_we_high = 1;
    push(1, 8'h00); push(1, 8'h80); push(2, 8'h07); push(2, 8'hEF); push(2, 8'hBE);
    for (int i = 0; i < 4; i++) push(3, 8'h50 + 8'(i));
    push(1, 8'h10);
    run_op(3'd1, 2'd0, 8'h07, 16'hBEEF, 10'd4, 4);
    check_log("R5 program sequence");
    chk(!got_err && t_done > t_rb_rise, "R5 program ends after ready", got_err, 0);
    chk(we_lo_min == 5.0 && we_lo_max == 5.0, "R10 zero low width acts as one", int'(we_lo_max), 5);
    cfg_we_low = 2; cfg_we_high = 2;
  endtask

  task automatic t_erase();
    clear(); trig_addr_n = 0; busy_cycles = 10;
    push(1, 8'h60); push(2, 8'h02); push(2, 8'h01); push(1, 8'hD0);
    run_op(3'd2, 2'd0, 8'hAA, 16'h0102, 10'd1, 0);
    check_log("R6 erase sequence");
    chk(!got_err && t_done > t_rb_rise, "R6 erase waits for ready", got_err, 0);
  endtask

  task automatic t_status_sig();
    clear(); trig_addr_n = 0; dbase = 8'hC0;
    push(1, 8'h70);
    run_op(3'd3, 2'd0, 8'h00, 16'h0, 10'd9, 0);
    check_log("R7 status command");
    chk(rx_n == 1 && rx[0] == 8'hC0, "R7 status byte", rx[0], 8'hC0);
    clear(); dbase = 8'h20;
    push(1, 8'h90); push(2, 8'h00);
    run_op(3'd4, 2'd0, 8'h55, 16'h0, 10'd9, 0);
    check_log("R7 signature command");
    chk(rx_n == 2 && rx[0] == 8'h20 && rx[1] == 8'h21, "R7 signature two bytes", rx_n, 2);
  endtask

  task automatic t_reset_cmd();
    clear(); busy_cycles = 20;
    push(1, 8'hFF);
    run_op(3'd5, 2'd0, 8'h0, 16'h0, 10'd1, 0);
    check_log("R8 reset command");
    chk(!got_err && t_done > t_rb_rise, "R8 done after ready", got_err, 0);
  endtask

  task automatic t_timeout();
    clear(); busy_cycles = 1000; cfg_busy_limit = 50;
    run_op(3'd5, 2'd0, 8'h0, 16'h0, 10'd1, 0);
    chk(got_err == 1, "R11 timeout error", got_err, 1);
    chk(nf_rb == 0, "R11 ended while still busy", nf_rb, 0);
    cfg_busy_limit = 500;
    wait_ready();
  endtask

  task automatic t_wp();
    clear(); wp_allow = 0;
    #1 chk(nf_wp_n == 0, "R12 write-protect pin follows", nf_wp_n, 0);
    run_op(3'd1, 2'd0, 8'h0, 16'h0, 10'd4, 0);
    chk(got_err == 1, "R12 program refused", got_err, 1);
    chk(lg_n == 0, "R12 no bus cycle on refusal", lg_n, 0);
    run_op(3'd2, 2'd0, 8'h0, 16'h0, 10'd1, 0);
    chk(got_err == 1 && lg_n == 0, "R12 erase refused", lg_n, 0);
    wp_allow = 1;
  endtask

  task automatic t_bad_op();
    clear();
    run_op(3'd7, 2'd0, 8'h0, 16'h0, 10'd1, 0);
    chk(got_err == 1 && lg_n == 0, "R14 undefined op", lg_n, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    int k;
    clear(); trig_addr_n = 3; busy_cycles = 4; dbase = 8'h70; rd_ready = 0;
    @(posedge clk); #1;
    req_op = 0; req_area = 0; req_col = 0; req_row = 0; req_len = 2; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    k = 0;
    while (!rd_valid && k < 2000) begin @(negedge clk); k++; end
    held = rd_data;
    repeat (8) @(negedge clk);
    chk(rd_valid && rd_data == held, "R13 byte held while stalled", rd_data, held);
    chk(re_falls == 1, "R13 no read strobe while stalled", re_falls, 1);
    @(posedge clk); #1 rd_ready = 1;
    k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    chk(rx_n == 2 && rx[0] == 8'h70 && rx[1] == 8'h71, "R13 stalled read data", rx_n, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_read(2'd0, 8'h5A, 8'h00, 8'h5A, "R2 R3 first-half read");
    t_read(2'd1, 8'h5A, 8'h01, 8'h5A, "R3 second-half read");
    t_read(2'd2, 8'hF7, 8'h50, 8'h07, "R4 spare read");
    t_program();
    t_erase();
    t_status_sig();
    t_reset_cmd();
    t_timeout();
    t_wp();
    t_bad_op();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule